// File: doc/BRIEF.md
# Left-Justified Stereo Audio Transmitter

This block feeds a playback converter that runs as a clock slave. A host writes 32-bit stereo words into an on-chip sample queue. The left sample sits in the upper half of each word and the right sample in the lower half. The host watches a full flag and writes only while space remains. The block runs from the converter's master clock and creates both frame clocks itself. It sends one stereo word per frame, MSB first, in left-justified format.

With default parameters, one frame lasts 384 master clocks, which gives a 48 kHz rate from an 18.432 MHz master clock. Each channel half-frame holds 32 bit-clock slots of 6 master clocks each. The 16 sample bits fill the first 16 slots and the rest carry zeros. The queue holds 1024 stereo words, which is 4 KiB. The next word is taken from the queue in the last master clock of a frame. If the queue is empty at that point, the next frame is silent. The clocks never stop.

Top module: `lj_audio_tx`

## Requirements
- R1: While reset is held, `word_clk` is 1, `bit_clk` is 0, `ser_data` is 0 and `fifo_full` is 0.
- R2: `word_clk` is high for exactly MCLK_RATIO/2 (192) master clocks, which is the left channel, and then low for the same count, which is the right channel. This repeats with no gaps.
- R3: `bit_clk` has a period of BCLK_DIV (6) master clocks, low for the first half and high for the second half. Every `word_clk` phase holds exactly 32 rising edges of `bit_clk`.
- R4: `word_clk` and `ser_data` change only in a master clock where `bit_clk` falls. The receiver therefore samples stable data on each rising edge.
- R5: The MSB of a channel sample is on `ser_data` at the first `bit_clk` rising edge after a `word_clk` edge, with no one-slot delay. The remaining bits follow MSB first. The 16 slots after the last sample bit carry 0.
- R6: `wr_data[31:16]` is sent while `word_clk` is high, and `wr_data[15:0]` is sent while `word_clk` is low.
- R7: Stereo words play one per frame, in write order. A word that is queued during a frame plays no earlier than the next frame.
- R8: If the queue is empty at a frame boundary, the following frame sends zero on both channels. The first frame after reset is silent. The frame clocks keep running in both cases.
- R9: `fifo_full` is 1 exactly when FIFO_DEPTH words are held. A write made while `fifo_full` is 1 is dropped and never plays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, MCLK_RATIO times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the sample queue |
| wr_data | input | 32 | Stereo word: left in [31:16], right in [15:0] |
| fifo_full | output | 1 | The queue holds FIFO_DEPTH words |
| bit_clk | output | 1 | Serial bit clock to the converter |
| word_clk | output | 1 | Channel clock: 1 = left, 0 = right |
| ser_data | output | 1 | Serial sample data, MSB first |

## Verification
The timing properties need no conditions on the inputs, because the frame clocks run freely. The overflow property assumes that a write and a pop never meet on a full queue without a frame boundary. The bench keeps to this by writing each batch of at most FIFO_DEPTH words right after a frame has started, far from the next pop. The bench writes at most one word every two master clocks. It refills the queue only after it has drained, so every frame in which a word plays is known arithmetically from the frame counter that the bench derives from `word_clk`.

// File: rtl/ljtx_pkg.sv
package ljtx_pkg;
  localparam int unsigned SMP_W = 16;

  typedef logic [SMP_W-1:0] sample_t;

  typedef struct packed {
    sample_t left;
    sample_t right;
  } stereo_t;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;
endpackage

// File: rtl/ljtx_clkgen.sv
module ljtx_clkgen
  import ljtx_pkg::*;
#(
  parameter int unsigned BCLK_DIV = 6,
  parameter int unsigned SLOTS    = 32,
  localparam int unsigned DW = $clog2(BCLK_DIV),
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          bit_clk,
  output chan_e         chan,
  output logic [SW-1:0] slot,
  output logic          frame_end
);
  logic [DW-1:0] div_q, div_d;
  logic [SW-1:0] slot_q, slot_d;
  chan_e         chan_q, chan_d;
  logic          div_end, slot_end;

  always_comb begin
    div_end  = (div_q == DW'(BCLK_DIV - 1));
    slot_end = (slot_q == SW'(SLOTS - 1));
    div_d    = div_end ? '0 : div_q + 1'b1;
    slot_d   = slot_q;
    chan_d   = chan_q;
    if (div_end) begin
      slot_d = slot_end ? '0 : slot_q + 1'b1;
      if (slot_end) chan_d = (chan_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
      chan_q <= CH_LEFT;
    end else begin
      div_q <= div_d;
      if (div_end) begin
        slot_q <= slot_d;
        chan_q <= chan_d;
      end
    end
  end

  assign bit_clk   = (div_q >= DW'(BCLK_DIV / 2));
  assign chan      = chan_q;
  assign slot      = slot_q;
  assign frame_end = div_end && slot_end && (chan_q == CH_RIGHT);
endmodule

// File: rtl/ljtx_fifo.sv
module ljtx_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wp_d  = push_ok ? ((wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d  = pop_ok  ? ((rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_d = cnt_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  assign head = mem[rp_q];
  assign fill = cnt_q;
endmodule

// File: rtl/ljtx_serial.sv
module ljtx_serial
  import ljtx_pkg::*;
#(
  parameter int unsigned SLOTS = 32,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned IW = $clog2(SMP_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic          avail,
  input  stereo_t       next_word,
  input  chan_e         chan,
  input  logic [SW-1:0] slot,
  output stereo_t       hold,
  output logic          ser_data
);
  stereo_t       hold_q, hold_d;
  sample_t       active;
  logic [IW-1:0] idx;
  logic          in_word;

  always_comb begin
    hold_d = avail ? next_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (frame_end) hold_q <= hold_d;
  end

  always_comb begin
    active   = (chan == CH_LEFT) ? hold_q.left : hold_q.right;
    in_word  = (32'(slot) < SMP_W);
    idx      = IW'(SMP_W - 1) - IW'(slot);
    ser_data = in_word && active[idx];
  end

  assign hold = hold_q;
endmodule

// File: rtl/lj_audio_tx.sv
module lj_audio_tx
  import ljtx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 1024,
  parameter int unsigned MCLK_RATIO = 384,
  parameter int unsigned BCLK_DIV   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2*SMP_W-1:0] wr_data,
  output logic               fifo_full,
  output logic               bit_clk,
  output logic               word_clk,
  output logic               ser_data
);
  localparam int unsigned LR_HALF = MCLK_RATIO / 2;
  localparam int unsigned SLOTS   = LR_HALF / BCLK_DIV;
  localparam int unsigned SW      = $clog2(SLOTS);
  localparam int unsigned FILL_W  = $clog2(FIFO_DEPTH + 1);

  logic [2*SMP_W-1:0] head_vec;
  logic               fifo_empty;
  logic [FILL_W-1:0]  fifo_fill;
  logic               frame_end;
  chan_e              chan;
  logic [SW-1:0]      slot;
  stereo_t            hold;

  ljtx_clkgen #(.BCLK_DIV(BCLK_DIV), .SLOTS(SLOTS)) u_clk (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .chan(chan),
    .slot(slot), .frame_end(frame_end)
  );

  ljtx_fifo #(.W(2 * SMP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
    .pop(frame_end), .head(head_vec), .empty(fifo_empty),
    .full(fifo_full), .fill(fifo_fill)
  );

  ljtx_serial #(.SLOTS(SLOTS)) u_ser (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .avail(!fifo_empty),
    .next_word(stereo_t'(head_vec)), .chan(chan), .slot(slot),
    .hold(hold), .ser_data(ser_data)
  );

  assign word_clk = (chan == CH_LEFT);
endmodule

// File: rtl/ljtx_chk.sv
module ljtx_chk
  import ljtx_pkg::*;
#(
  parameter int unsigned LR_HALF    = 192,
  parameter int unsigned BCLK_DIV   = 6,
  parameter int unsigned FIFO_DEPTH = 1024,
  parameter int unsigned SW         = 5,
  parameter int unsigned FILL_W     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_clk,
  input logic              word_clk,
  input logic              ser_data,
  input logic              wr_en,
  input logic              fifo_full,
  input logic              frame_end,
  input logic [SW-1:0]     slot,
  input logic [FILL_W-1:0] fill,
  input stereo_t           hold
);
  logic        lr_prev, bk_prev;
  int unsigned lr_len, bk_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev <= 1'b1;
      bk_prev <= 1'b0;
      lr_len  <= 0;
      bk_len  <= 0;
    end else begin
      lr_prev <= word_clk;
      bk_prev <= bit_clk;
      lr_len  <= (word_clk != lr_prev) ? 1 : lr_len + 1;
      bk_len  <= (bit_clk != bk_prev) ? 1 : bk_len + 1;
    end
  end

  p_lrck_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_clk != lr_prev) |-> (lr_len == LR_HALF));

  p_bclk_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clk != bk_prev) |-> (bk_len == BCLK_DIV / 2));

  p_lrck_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_clk) |-> $fell(bit_clk));

  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> $fell(bit_clk));

  p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(slot) >= SMP_W) |-> !ser_data);

  p_silence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (fill == '0)) |=> (hold == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !frame_end) |=> $stable(fill));

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fill) <= FIFO_DEPTH));
endmodule

bind lj_audio_tx ljtx_chk #(
  .LR_HALF(LR_HALF), .BCLK_DIV(BCLK_DIV), .FIFO_DEPTH(FIFO_DEPTH),
  .SW(SW), .FILL_W(FILL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .word_clk(word_clk),
  .ser_data(ser_data), .wr_en(wr_en), .fifo_full(fifo_full),
  .frame_end(frame_end), .slot(slot), .fill(fifo_fill), .hold(hold)
);

// File: tb/sim_lj_audio_tx.sv
module sim_lj_audio_tx;
  localparam int DEPTH  = 8;
  localparam int LRH    = 192;
  localparam int BHALF  = 3;
  localparam int NSLOT  = 32;
  localparam int NFRAME = 39;

  logic clk, rst_n, wr_en, fifo_full, bit_clk, word_clk, ser_data;
  logic [31:0] wr_data;
  int total = 0, bad = 0;
  bit done = 0;
  logic mon_on;

  logic [15:0] exp_l [64], exp_r [64], cap_l [64], cap_r [64];
  int frames_done = 0;

  lj_audio_tx #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .bit_clk(bit_clk), .word_clk(word_clk),
    .ser_data(ser_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) mon_on <= rst_n;

  // serial monitor: frames rebuilt from the pins
  logic p_lr = 1'b1, p_bk = 1'b0, p_sd = 1'b0;
  int lr_run = 1, bk_run = 1, nbits = 0;
  logic [31:0] sh = '0;
  always @(negedge clk) begin
    if (mon_on === 1'b1) begin
      if (bit_clk != p_bk) begin
        chk(bk_run == BHALF, "R3", "bit_clk half length", bk_run, BHALF);
        bk_run = 1;
      end else bk_run++;
      if (ser_data != p_sd)
        chk(p_bk && !bit_clk, "R4", "data change off bit_clk fall", bit_clk, 0);
      if (bit_clk && !p_bk) begin
        sh = {sh[30:0], ser_data};
        nbits++;
      end
      if (word_clk != p_lr) begin
        chk(lr_run == LRH, "R2", "word_clk phase length", lr_run, LRH);
        chk(p_bk && !bit_clk, "R4", "word_clk edge off bit_clk fall", bit_clk, 0);
        chk(nbits == NSLOT, "R3", "bit_clk rises per phase", nbits, NSLOT);
        chk(sh[15:0] == 16'h0, "R5", "trailing slots", sh[15:0], 0);
        if (frames_done < 64) begin
          if (p_lr) cap_l[frames_done] = sh[31:16];
          else      cap_r[frames_done] = sh[31:16];
        end
        if (!p_lr) frames_done++;
        nbits = 0;
        sh = '0;
        lr_run = 1;
      end else lr_run++;
      p_lr = word_clk;
      p_bk = bit_clk;
      p_sd = ser_data;
    end
  end

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {l, r};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frame(input int f);
    while (frames_done < f) @(negedge clk);
  endtask

  initial begin
    for (int f = 0; f < 64; f++) begin
      exp_l[f] = '0; exp_r[f] = '0; cap_l[f] = 16'hxxxx; cap_r[f] = 16'hxxxx;
    end
    wr_en = 0; wr_data = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk(word_clk == 1'b1, "R1", "word_clk in reset", word_clk, 1);
    chk(bit_clk == 1'b0, "R1", "bit_clk in reset", bit_clk, 0);
    chk(ser_data == 1'b0, "R1", "ser_data in reset", ser_data, 0);
    chk(fifo_full == 1'b0, "R1", "fifo_full in reset", fifo_full, 0);
    rst_n = 1;

    // batch 0 in frame 0: arithmetic words, plays in frames 1..8
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] l, r;
      l = 16'(16'h1111 * (i + 1));
      r = 16'hF00F ^ 16'(i * 16'h0101);
      push(l, r);
      exp_l[1 + i] = l; exp_r[1 + i] = r;
      if (i == DEPTH - 2) chk(fifo_full == 1'b0, "R9", "full one short", fifo_full, 0);
    end
    chk(fifo_full == 1'b1, "R9", "full at depth", fifo_full, 1);
    push(16'hDEAD, 16'hBEEF);  // dropped: frame 9 stays silent
    chk(fifo_full == 1'b1, "R9", "full after dropped write", fifo_full, 1);

    wait_frame(10);
    chk(fifo_full == 1'b0, "R9", "full cleared after drain", fifo_full, 0);
    for (int i = 0; i < DEPTH; i++) begin
      exp_l[11 + i] = 16'(1) << i;
      exp_r[11 + i] = 16'(1) << (i + 8);
      push(exp_l[11 + i], exp_r[11 + i]);
    end
    wait_frame(19);
    for (int i = 0; i < DEPTH; i++) begin
      exp_l[20 + i] = ~(16'(1) << i);
      exp_r[20 + i] = ~(16'(1) << (i + 8));
      push(exp_l[20 + i], exp_r[20 + i]);
    end
    wait_frame(28);
    for (int i = 0; i < DEPTH; i++) begin
      exp_l[29 + i] = 16'(1) << (i + 8);
      exp_r[29 + i] = 16'(1) << i;
      push(exp_l[29 + i], exp_r[29 + i]);
    end
    wait_frame(NFRAME);

    for (int f = 0; f < NFRAME; f++) begin
      if (exp_l[f] == 16'h0 && exp_r[f] == 16'h0) begin
        chk(cap_l[f] === 16'h0, "R8", $sformatf("silent frame %0d left", f), cap_l[f], 0);
        chk(cap_r[f] === 16'h0, "R8", $sformatf("silent frame %0d right", f), cap_r[f], 0);
      end else begin
        chk(cap_l[f] === exp_l[f], "R6 R7", $sformatf("frame %0d left", f), cap_l[f], exp_l[f]);
        chk(cap_r[f] === exp_r[f], "R6 R7", $sformatf("frame %0d right", f), cap_r[f], exp_r[f]);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog frames actual=%0d expected=%0d", frames_done, NFRAME);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule